// File: doc/BRIEF.md
# Interrupt Link Load-Balancing Allocator

This block hands out interrupt links to devices as they are enumerated. Each allocate request names the device's slot and interrupt pin and carries a mode bit. In fixed mode the link comes from a slot-and-pin formula. In balanced mode the block picks the link with the fewest devices so far. The block keeps a use count for each of the eight links and reports the chosen link as a one-based number.

When the chosen link has not yet been steered to a legacy IRQ, the block then picks the least-loaded IRQ that is still eligible. It raises a one-cycle write toward the link router that steers the link to that IRQ. The IRQs that may be used form a fixed permitted set. Before the first allocation, software-side setup may reserve further IRQs to keep them out of the pool.

Both searches are sequential scans that examine one entry per clock. A request is accepted only while the block is idle.

Top module: `irq_link_alloc`

## Requirements
- R1: With `alloc_fixed`=1 the chosen link index is (4 + `alloc_slot` + `alloc_pin`) mod 8, and `done_link` reports that index plus one (1 to 8).
- R2: With `alloc_fixed`=0 the link with the smallest use count is chosen; on a tie the lowest link index wins.
- R3: Every accepted allocation raises the chosen link's use count by one, in both modes, so the count affects later balanced choices.
- R4: If the chosen link is still unrouted, the block picks the eligible IRQ with the lowest load, with ties going to the lowest IRQ number. It pulses `wr_valid` together with `done`, with `wr_link` equal to `done_link` and `wr_data` = {4'b0000, irq}. It raises that IRQ's load by one and marks the link routed, so later allocations of the same link write nothing.
- R5: After reset only IRQs 3-7, 9-12 and 14-15 are eligible; no other IRQ number ever appears on `wr_data`.
- R6: A `reserve_req` pulse while idle and before any allocation makes IRQ `reserve_irq` ineligible.
- R7: A `reserve_req` after the first allocation has no effect on IRQ choice and sets `reserve_err`, which stays high until reset.
- R8: `done` is high for exactly one cycle per allocation, and only while `busy` is high. An `alloc_req` raised while `busy` is high is ignored: it produces no `done` and changes no use count.
- R9: After reset `busy`, `done`, `wr_valid` and `reserve_err` are all 0.
- R10: If no IRQ is eligible, an allocation of an unrouted link still completes with the correct `done_link` but produces no write, and the link stays unrouted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate request, taken when idle |
| alloc_fixed | input | 1 | 1: fixed slot/pin mapping, 0: balanced |
| alloc_slot | input | 5 | Device slot number |
| alloc_pin | input | 3 | Device interrupt pin number |
| reserve_req | input | 1 | Reserve request, taken when idle and no allocate request |
| reserve_irq | input | 4 | IRQ number to reserve |
| busy | output | 1 | Allocation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_link | output | 4 | Chosen link, one-based |
| wr_valid | output | 1 | Link router register write strobe |
| wr_link | output | 4 | Link to write, one-based |
| wr_data | output | 8 | Value to write: IRQ number, enable bit clear |
| reserve_err | output | 1 | Sticky: reserve came after an allocation |

## Verification
Balanced allocations are run from a fresh reset, both with and without reservations, and from states where every link has been routed. These runs separate the link tie-break from the IRQ tie-break, and routed links from unrouted ones. A full sweep of slots 0-7 against pins 1-4 in fixed mode checks the modulo formula and shows that fixed allocations also feed the use counts read by later balanced picks. A reserve sent after the first allocation, a request pulsed in the middle of a scan, and a setup where every IRQ is reserved each probe the paths that must leave the choices untouched.

// File: rtl/irq_link_alloc_pkg.sv
package irq_link_alloc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LSCAN = 3'd1,
        ST_ROUTE = 3'd2,
        ST_ISCAN = 3'd3,
        ST_FIN   = 3'd4
    } ila_state_e;

    localparam int          LOAD_W      = 8;
    localparam logic [7:0]  LOAD_EXCL   = 8'hFF;
    localparam logic [7:0]  LOAD_MAX    = 8'hFE;
    localparam logic [15:0] PERMIT_DFLT = 16'hDEF8;
endpackage

// File: rtl/ila_fixed_map.sv
module ila_fixed_map #(
    parameter int NUM_LINKS = 8,
    parameter int SLOT_W    = 5,
    parameter int PIN_W     = 3,
    localparam int LINK_W   = $clog2(NUM_LINKS),
    localparam int SUM_W    = ((SLOT_W > PIN_W) ? SLOT_W : PIN_W) + 4
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [PIN_W-1:0]  pin,
    output logic [LINK_W-1:0] link
);
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rem;

    always_comb begin
        sum  = SUM_W'(4) + SUM_W'(slot) + SUM_W'(pin);
        rem  = sum % SUM_W'(NUM_LINKS);
        link = rem[LINK_W-1:0];
    end
endmodule

// File: rtl/ila_min_step.sv
module ila_min_step #(
    parameter int W = 8
) (
    input  logic         cand_ok,
    input  logic [W-1:0] cand_cnt,
    input  logic         have_best,
    input  logic [W-1:0] best_cnt,
    output logic         take
);
    always_comb begin
        take = cand_ok && (!have_best || (cand_cnt < best_cnt));
    end
endmodule

// File: rtl/irq_link_alloc.sv
module irq_link_alloc
    import irq_link_alloc_pkg::*;
#(
    parameter int          NUM_LINKS = 8,
    parameter int          NUM_IRQS  = 16,
    parameter int          USE_W     = 8,
    parameter int          SLOT_W    = 5,
    parameter int          PIN_W     = 3,
    parameter logic [15:0] PERMIT    = PERMIT_DFLT,
    localparam int LINK_W = $clog2(NUM_LINKS),
    localparam int IRQ_W  = $clog2(NUM_IRQS),
    localparam int IDX_W  = (LINK_W > IRQ_W) ? LINK_W : IRQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic              alloc_fixed,
    input  logic [SLOT_W-1:0] alloc_slot,
    input  logic [PIN_W-1:0]  alloc_pin,
    input  logic              reserve_req,
    input  logic [IRQ_W-1:0]  reserve_irq,
    output logic              busy,
    output logic              done,
    output logic [LINK_W:0]   done_link,
    output logic              wr_valid,
    output logic [LINK_W:0]   wr_link,
    output logic [7:0]        wr_data,
    output logic              reserve_err
);
    typedef struct packed {
        ila_state_e                         st;
        logic [IDX_W-1:0]                   idx;
        logic [LINK_W-1:0]                  link;
        logic [USE_W-1:0]                   lcnt;
        logic [IRQ_W-1:0]                   irq;
        logic [LOAD_W-1:0]                  icnt;
        logic                               found;
        logic                               route;
        logic                               started;
        logic                               err;
        logic [NUM_LINKS-1:0][USE_W-1:0]    use_cnt;
        logic [NUM_IRQS-1:0][LOAD_W-1:0]    load;
        logic [NUM_LINKS-1:0]               link_off;
        logic [NUM_LINKS-1:0][IRQ_W-1:0]    link_irq;
    } ila_regs_t;

    function automatic ila_regs_t reset_regs();
        ila_regs_t v;
        v = '0;
        v.st = ST_IDLE;
        for (int i = 0; i < NUM_IRQS; i++) begin
            v.load[i] = PERMIT[i] ? '0 : LOAD_EXCL;
        end
        v.link_off = '1;
        return v;
    endfunction

    ila_regs_t r_q, r_d;

    logic [LINK_W-1:0] fixed_link;
    logic              l_take;
    logic              i_take;
    logic [LINK_W-1:0] l_idx;
    logic [IRQ_W-1:0]  i_idx;

    assign l_idx = r_q.idx[LINK_W-1:0];
    assign i_idx = r_q.idx[IRQ_W-1:0];

    ila_fixed_map #(
        .NUM_LINKS(NUM_LINKS), .SLOT_W(SLOT_W), .PIN_W(PIN_W)
    ) u_fixed (
        .slot(alloc_slot), .pin(alloc_pin), .link(fixed_link)
    );

    ila_min_step #(.W(USE_W)) u_lmin (
        .cand_ok(1'b1), .cand_cnt(r_q.use_cnt[l_idx]),
        .have_best(1'b1), .best_cnt(r_q.lcnt), .take(l_take)
    );

    ila_min_step #(.W(LOAD_W)) u_imin (
        .cand_ok(r_q.load[i_idx] != LOAD_EXCL), .cand_cnt(r_q.load[i_idx]),
        .have_best(r_q.found), .best_cnt(r_q.icnt), .take(i_take)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (alloc_req) begin
                    r_d.started = 1'b1;
                    if (alloc_fixed) begin
                        r_d.link = fixed_link;
                        r_d.st   = ST_ROUTE;
                    end else begin
                        r_d.link = '0;
                        r_d.lcnt = r_q.use_cnt[0];
                        r_d.idx  = IDX_W'(1);
                        r_d.st   = ST_LSCAN;
                    end
                end else if (reserve_req) begin
                    if (r_q.started) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.load[reserve_irq] = LOAD_EXCL;
                    end
                end
            end
            ST_LSCAN: begin
                if (l_take) begin
                    r_d.link = l_idx;
                    r_d.lcnt = r_q.use_cnt[l_idx];
                end
                r_d.idx = r_q.idx + IDX_W'(1);
                if (l_idx == LINK_W'(NUM_LINKS - 1)) begin
                    r_d.st = ST_ROUTE;
                end
            end
            ST_ROUTE: begin
                if (r_q.use_cnt[r_q.link] != '1) begin
                    r_d.use_cnt[r_q.link] = r_q.use_cnt[r_q.link] + USE_W'(1);
                end
                r_d.idx   = '0;
                r_d.found = 1'b0;
                r_d.route = r_q.link_off[r_q.link];
                r_d.st    = r_q.link_off[r_q.link] ? ST_ISCAN : ST_FIN;
            end
            ST_ISCAN: begin
                if (i_take) begin
                    r_d.irq   = i_idx;
                    r_d.icnt  = r_q.load[i_idx];
                    r_d.found = 1'b1;
                end
                r_d.idx = r_q.idx + IDX_W'(1);
                if (i_idx == IRQ_W'(NUM_IRQS - 1)) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                if (r_q.route && r_q.found) begin
                    if (r_q.load[r_q.irq] < LOAD_MAX) begin
                        r_d.load[r_q.irq] = r_q.load[r_q.irq] + LOAD_W'(1);
                    end
                    r_d.link_off[r_q.link] = 1'b0;
                    r_d.link_irq[r_q.link] = r_q.irq;
                end
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= reset_regs();
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign done        = (r_q.st == ST_FIN);
    assign done_link   = {1'b0, r_q.link} + (LINK_W+1)'(1);
    assign wr_valid    = done && r_q.route && r_q.found;
    assign wr_link     = done_link;
    assign wr_data     = 8'(r_q.irq);
    assign reserve_err = r_q.err;
endmodule

// File: rtl/irq_link_alloc_chk.sv
module irq_link_alloc_chk #(
    parameter int          NUM_LINKS = 8,
    parameter int          SLOT_W    = 5,
    parameter int          PIN_W     = 3,
    parameter int          IRQ_W     = 4,
    parameter logic [15:0] PERMIT    = 16'hDEF8,
    localparam int LINK_W = $clog2(NUM_LINKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_req,
    input logic              alloc_fixed,
    input logic [SLOT_W-1:0] alloc_slot,
    input logic [PIN_W-1:0]  alloc_pin,
    input logic              reserve_req,
    input logic              busy,
    input logic              done,
    input logic [LINK_W:0]   done_link,
    input logic              wr_valid,
    input logic [LINK_W:0]   wr_link,
    input logic [7:0]        wr_data,
    input logic              reserve_err
);
    logic        fx_pend;
    logic [31:0] fx_exp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fx_pend <= 1'b0;
            fx_exp  <= '0;
        end else if (!busy && alloc_req) begin
            fx_pend <= alloc_fixed;
            fx_exp  <= (32'd4 + 32'(alloc_slot) + 32'(alloc_pin)) % NUM_LINKS + 32'd1;
        end else if (done) begin
            fx_pend <= 1'b0;
        end
    end

    AST_FIXED_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fx_pend) |-> (32'(done_link) == fx_exp)); // R1
    AST_LINK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_link >= 1 && 32'(done_link) <= NUM_LINKS)); // R1
    AST_WR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (done && wr_link == done_link)); // R4
    AST_WR_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (PERMIT[wr_data[IRQ_W-1:0]] && wr_data[7:IRQ_W] == '0)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        reserve_err |=> reserve_err); // R7
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reserve_err) |-> $past(reserve_req && !busy)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R8
endmodule

bind irq_link_alloc irq_link_alloc_chk #(
    .NUM_LINKS(NUM_LINKS), .SLOT_W(SLOT_W), .PIN_W(PIN_W),
    .IRQ_W(IRQ_W), .PERMIT(PERMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_fixed(alloc_fixed),
    .alloc_slot(alloc_slot), .alloc_pin(alloc_pin), .reserve_req(reserve_req),
    .busy(busy), .done(done), .done_link(done_link), .wr_valid(wr_valid),
    .wr_link(wr_link), .wr_data(wr_data), .reserve_err(reserve_err)
);

// File: tb/irq_link_alloc_bench.sv
`timescale 1ns/1ps
module irq_link_alloc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 1'b0;
    logic       alloc_fixed = 1'b0;
    logic [4:0] alloc_slot = '0;
    logic [2:0] alloc_pin = '0;
    logic       reserve_req = 1'b0;
    logic [3:0] reserve_irq = '0;
    logic       busy, done, wr_valid, reserve_err;
    logic [3:0] done_link, wr_link;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int use_m [8];
    int load_m [16];
    bit off_m [8];
    bit started_m;

    always #5 clk = ~clk;

    irq_link_alloc u_irq_link_alloc (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_fixed(alloc_fixed),
        .alloc_slot(alloc_slot), .alloc_pin(alloc_pin), .reserve_req(reserve_req),
        .reserve_irq(reserve_irq), .busy(busy), .done(done), .done_link(done_link),
        .wr_valid(wr_valid), .wr_link(wr_link), .wr_data(wr_data),
        .reserve_err(reserve_err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic bit permitted(int i);
        return ((16'hDEF8 >> i) & 16'h1) != 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        alloc_req = 1'b0;
        reserve_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            use_m[i] = 0;
            off_m[i] = 1'b1;
        end
        for (int i = 0; i < 16; i++) load_m[i] = permitted(i) ? 0 : 255;
        started_m = 1'b0;
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        check("R9 wr_valid", wr_valid, 0);
        check("R9 reserve_err", reserve_err, 0);
    endtask

    task automatic reserve(int irq);
        @(negedge clk);
        reserve_req = 1'b1;
        reserve_irq = 4'(irq);
        @(negedge clk);
        reserve_req = 1'b0;
        if (started_m) begin
            check("R7 reserve_err set", reserve_err, 1);
        end else begin
            load_m[irq] = 255;
            check("R6 no error before first allocation", reserve_err, 0);
        end
    endtask

    task automatic alloc(bit fixed, int slot, int pin, bit poke);
        int elink;
        int eirq;
        int best;
        bit route;
        int wait_n;
        if (fixed) begin
            elink = (4 + slot + pin) % 8;
        end else begin
            elink = 0;
            best = use_m[0];
            for (int i = 1; i < 8; i++) begin
                if (use_m[i] < best) begin
                    elink = i;
                    best = use_m[i];
                end
            end
        end
        use_m[elink] = use_m[elink] + 1;
        eirq = -1;
        best = 0;
        route = off_m[elink];
        if (route) begin
            for (int i = 0; i < 16; i++) begin
                if (load_m[i] != 255 && (eirq < 0 || load_m[i] < best)) begin
                    eirq = i;
                    best = load_m[i];
                end
            end
        end
        started_m = 1'b1;
        @(negedge clk);
        alloc_req = 1'b1;
        alloc_fixed = fixed;
        alloc_slot = 5'(slot);
        alloc_pin = 3'(pin);
        @(negedge clk);
        alloc_req = 1'b0;
        if (poke) begin
            check("R8 busy during scan", busy, 1);
            alloc_req = 1'b1;
            alloc_fixed = 1'b1;
            alloc_slot = 5'd3;
            alloc_pin = 3'd2;
            @(negedge clk);
            alloc_req = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 100) begin
            @(negedge clk);
            wait_n++;
        end
        check("R8 done seen", done, 1);
        check(fixed ? "R1 fixed link" : "R2 balanced link", done_link, elink + 1);
        if (route && eirq >= 0) begin
            check("R4 write strobe", wr_valid, 1);
            check("R4 write irq", wr_data, eirq);
            check("R4 write link", wr_link, elink + 1);
            check("R5 irq permitted", permitted(wr_data) ? 1 : 0, 1);
            load_m[eirq] = load_m[eirq] + 1;
            off_m[elink] = 1'b0;
        end else if (route) begin
            check("R10 no write when nothing eligible", wr_valid, 0);
        end else begin
            check("R4 routed link no write", wr_valid, 0);
        end
        @(negedge clk);
        check("R8 done one cycle", done, 0);
        check("R8 idle after done", busy, 0);
    endtask

    initial begin
        // Phase A: reservations, balanced fill, routed links, fixed sweep
        do_reset();
        reserve(3);
        reserve(9);
        alloc(1'b0, 0, 0, 1'b0);            // link 1, irq 4
        reserve(5);                         // R7: late, must not exclude 5
        alloc(1'b0, 0, 0, 1'b0);            // link 2, irq 5
        for (int k = 0; k < 6; k++) alloc(1'b0, 0, 0, k == 2); // R8 poke
        for (int k = 0; k < 8; k++) alloc(1'b0, 0, 0, 1'b0);   // R3 second round
        for (int s = 0; s < 8; s++) begin
            for (int p = 1; p <= 4; p++) alloc(1'b1, s, p, 1'b0);
        end
        for (int k = 0; k < 10; k++) alloc(1'b0, 0, 0, 1'b0);  // R3 after fixed
        check("R7 error sticky", reserve_err, 1);

        // Phase B: every IRQ reserved
        do_reset();
        for (int i = 0; i < 16; i++) if (permitted(i)) reserve(i);
        alloc(1'b1, 2, 1, 1'b0);            // R10
        alloc(1'b1, 2, 1, 1'b0);            // R10 link still unrouted
        alloc(1'b0, 0, 0, 1'b0);

        // Phase C: default exclusions only
        do_reset();
        for (int k = 0; k < 16; k++) alloc(1'b0, 0, 0, 1'b0); // R5
        alloc(1'b1, 31, 7, 1'b0);           // R1 wrap

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule